// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block copies a run of words from one memory region to another without processor help. Software first writes a source word address, a destination word address and a word count into a small register bank. It then writes a control word that picks the pacing mode and sets the start bit. From then on the engine works as a bus master. It raises a bus request, waits for the arbiter's grant, and for each word issues one read cycle followed by one write cycle. When the count is used up it releases the bus and sets a done flag.

Two pacing modes exist. In continuous mode the engine keeps the bus from the grant until the last word, so one word moves every two cycles. In cycle-steal mode it lets go of the request for N-1 cycles after each word. During that gap the arbiter may give the bus to the processor. The engine then asks again and waits for a new grant. The bus has a single shared address output, separate read and write strobes, and read data that the addressed memory returns in the same cycle as the read strobe.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset bus_req, m_rd and m_wr are low, and every register selected by reg_sel (0 source, 1 destination, 2 length, 3 control, 4 status) reads as zero.
- R2: While the engine is idle, a write to index 0, 1 or 2 stores the value, and it reads back unchanged. The length keeps its low LEN_W bits. Control reads back bit1 as the mode and bits[7:4] as N; bit0 (start) always reads as 0.
- R3: A control write with bit0=1 and a nonzero length makes status bit0 (busy) and bus_req high from the next cycle. The first m_rd comes in the cycle after the first cycle in which bus_gnt is sampled high.
- R4: Word i is read with m_rd=1 and m_addr=source+i, and m_rdata is taken in that cycle. In the next cycle the same word is written with m_wr=1, m_addr=destination+i and m_wdata equal to the data read. m_rd and m_wr are never high together.
- R5: In continuous mode (control bit1=0), bus_req stays high from the grant to the last write, and read/write pairs follow each other with no idle cycle.
- R6: In cycle-steal mode (control bit1=1), after every write except the last, bus_req is low for N-1 cycles, where N is control bits[7:4] and a value of 0 counts as 1. The engine then requests again, and the next read waits for a grant as in R3.
- R7: In the cycle after the final write, bus_req is low and busy is still 1. In the cycle after that, busy reads 0 and status bit1 (done) reads 1.
- R8: A start with a stored length of zero sets done on the next cycle. Busy stays 0 and bus_req is never raised.
- R9: While busy, writes to indices 0 to 3 (including a new start) change neither the stored registers nor the running transfer.
- R10: Writing status (index 4) with bit1=1 clears done at any time, busy or not. Writing it with bit1=0 leaves done unchanged. If a clear and a completion happen in the same cycle, done ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index (0 src, 1 dst, 2 len, 3 ctrl, 4 status) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the register selected by reg_sel |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| m_rd | output | 1 | Bus read cycle strobe |
| m_wr | output | 1 | Bus write cycle strobe |
| m_addr | output | ADDR_W | Word address of the current bus cycle |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, valid in the read cycle |

## Verification
The assertions assume two things about the environment. First, once the arbiter has granted the bus it keeps bus_gnt high for as long as the engine holds bus_req. Second, the memory presents the addressed word on m_rdata during the read cycle itself. The bench's arbiter follows bus_req half a cycle later, and it can hold the grant back to stretch the request phase. It never removes a grant while the request is still high. Memory contents come from a fixed function of the address, so every word that reaches m_wdata can be predicted from its source address, and source and destination regions never overlap.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_GAP   = 3'd4,
        ST_DONE  = 3'd5
    } dma_state_e;

    // register indices seen on reg_sel
    localparam logic [2:0] IDX_SRC  = 3'd0;
    localparam logic [2:0] IDX_DST  = 3'd1;
    localparam logic [2:0] IDX_LEN  = 3'd2;
    localparam logic [2:0] IDX_CTRL = 3'd3;
    localparam logic [2:0] IDX_STAT = 3'd4;

    // field positions
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_MODE_BIT  = 1;
    localparam int CTRL_GAP_LSB   = 4;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_DONE_BIT  = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int LEN_W = 16,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             done_set,
    output logic             go,
    output logic [REG_W-1:0] src_o,
    output logic [REG_W-1:0] dst_o,
    output logic [LEN_W-1:0] len_o,
    output logic             mode_o,
    output logic [GAP_W-1:0] gap_o
);

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [LEN_W-1:0] len;
        logic             mode;
        logic [GAP_W-1:0] gap;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;
    logic  accept;
    logic  zero_start;
    logic  clr_done;

    always_comb begin
        r_d        = r_q;
        go         = 1'b0;
        zero_start = 1'b0;
        // R9: programming registers are frozen while a transfer runs
        accept     = reg_we && !busy;
        if (accept) begin
            case (reg_sel)
                IDX_SRC: r_d.src = reg_wdata;
                IDX_DST: r_d.dst = reg_wdata;
                IDX_LEN: r_d.len = reg_wdata[LEN_W-1:0];
                IDX_CTRL: begin
                    r_d.mode = reg_wdata[CTRL_MODE_BIT];
                    r_d.gap  = reg_wdata[CTRL_GAP_LSB +: GAP_W];
                    if (reg_wdata[CTRL_START_BIT]) begin
                        // R8: empty transfer finishes without the bus
                        if (r_q.len == '0) zero_start = 1'b1;
                        else               go         = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        // R10: clear works in any state, completion wins a tie
        clr_done = reg_we && (reg_sel == IDX_STAT) && reg_wdata[STAT_DONE_BIT];
        if (done_set || zero_start) r_d.done = 1'b1;
        else if (clr_done)          r_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            IDX_SRC: reg_rdata = r_q.src;
            IDX_DST: reg_rdata = r_q.dst;
            IDX_LEN: reg_rdata = REG_W'(r_q.len);
            IDX_CTRL: begin
                reg_rdata[CTRL_MODE_BIT]             = r_q.mode;
                reg_rdata[CTRL_GAP_LSB +: GAP_W]     = r_q.gap;
            end
            IDX_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = busy;
                reg_rdata[STAT_DONE_BIT] = r_q.done;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign src_o  = r_q.src;
    assign dst_o  = r_q.dst;
    assign len_o  = r_q.len;
    assign mode_o = r_d.mode;
    assign gap_o  = r_d.gap;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_src,
    input  logic [ADDR_W-1:0] go_dst,
    input  logic [LEN_W-1:0]  go_len,
    input  logic              go_mode,
    input  logic [GAP_W-1:0]  go_gap,
    output logic              busy,
    output logic              done_set,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              m_rd,
    output logic              m_wr,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata
);

    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  rem;
        logic [DATA_W-1:0] data;
        logic              mode;
        logic [GAP_W-1:0]  n;
        logic [GAP_W-1:0]  cnt;
    } mv_t;

    mv_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        case (m_q.st)
            ST_IDLE: begin
                if (go) begin
                    m_d.src  = go_src;
                    m_d.dst  = go_dst;
                    m_d.rem  = go_len;
                    m_d.mode = go_mode;
                    m_d.n    = (go_gap == '0) ? GAP_ONE : go_gap;
                    m_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                // R3: no bus cycle before mastership is granted
                if (bus_gnt) m_d.st = ST_READ;
            end
            ST_READ: begin
                m_d.data = m_rdata;
                m_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                m_d.src = m_q.src + ADDR_W'(1);
                m_d.dst = m_q.dst + ADDR_W'(1);
                m_d.rem = m_q.rem - LEN_W'(1);
                if (m_q.rem == LEN_W'(1)) begin
                    m_d.st = ST_DONE;
                end else if (!m_q.mode) begin
                    m_d.st = ST_READ;           // R5: keep the bus
                end else if (m_q.n == GAP_ONE) begin
                    m_d.st = ST_REQ;            // R6: N of one, no gap
                end else begin
                    m_d.cnt = m_q.n - GAP_ONE;  // R6: release for N-1
                    m_d.st  = ST_GAP;
                end
            end
            ST_GAP: begin
                if (m_q.cnt == GAP_ONE) m_d.st  = ST_REQ;
                else                    m_d.cnt = m_q.cnt - GAP_ONE;
            end
            ST_DONE: m_d.st = ST_IDLE;
            default: m_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign busy     = (m_q.st != ST_IDLE);
    assign done_set = (m_q.st == ST_DONE);   // R7
    assign bus_req  = (m_q.st == ST_REQ) || (m_q.st == ST_READ) || (m_q.st == ST_WRITE);
    assign m_rd     = (m_q.st == ST_READ);
    assign m_wr     = (m_q.st == ST_WRITE);
    assign m_addr   = (m_q.st == ST_READ) ? m_q.src : m_q.dst;
    assign m_wdata  = m_q.data;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              m_rd,
    output logic              m_wr,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata
);

    logic              busy;
    logic              done_set;
    logic              go;
    logic [ADDR_W-1:0] cfg_src;
    logic [ADDR_W-1:0] cfg_dst;
    logic [LEN_W-1:0]  cfg_len;
    logic              cfg_mode;
    logic [GAP_W-1:0]  cfg_gap;

    dma_regs #(
        .REG_W (ADDR_W),
        .LEN_W (LEN_W),
        .GAP_W (GAP_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done_set  (done_set),
        .go        (go),
        .src_o     (cfg_src),
        .dst_o     (cfg_dst),
        .len_o     (cfg_len),
        .mode_o    (cfg_mode),
        .gap_o     (cfg_gap)
    );

    dma_mover #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .GAP_W  (GAP_W)
    ) mover_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_src   (cfg_src),
        .go_dst   (cfg_dst),
        .go_len   (cfg_len),
        .go_mode  (cfg_mode),
        .go_gap   (cfg_gap),
        .busy     (busy),
        .done_set (done_set),
        .bus_req  (bus_req),
        .bus_gnt  (bus_gnt),
        .m_rd     (m_rd),
        .m_wr     (m_wr),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .m_rdata  (m_rdata)
    );

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              m_rd,
    input logic              m_wr,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic [DATA_W-1:0] m_rdata
);

    // R4: a read cycle is always followed by its write cycle
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd |=> m_wr);

    // R4: the written word is the one returned by the read
    a_r4_data_carried: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd |=> (m_wdata == $past(m_rdata)));

    // R4: never both strobes at once
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rd && m_wr));

    // R3: a read that does not follow a write needs a grant first
    a_r3_grant_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && !$past(m_wr)) |-> $past(bus_gnt));

    // R5: bus cycles only while requesting mastership
    a_r5_req_covers_access: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd || m_wr) |-> bus_req);

    // R5: back-to-back reads step the source by one word
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && $past(m_wr)) |-> (m_addr == $past(m_addr, 2) + ADDR_W'(1)));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/dma_xfer_engine_tb_top.sv
module dma_xfer_engine_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = 3'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          m_rd, m_wr;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_rdata;

    bit    cpu_hold = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    wr_seen = 0;
    int    req_seen = 0;
    string cur = "R1";

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
    endfunction

    assign m_rdata = pattern(m_addr);

    dma_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    // arbiter: follows the request half a cycle later unless the CPU holds it
    always @(negedge clk) bus_gnt <= rst_n && bus_req && !cpu_hold;

    always @(posedge clk) begin
        if (rst_n && m_wr)    wr_seen++;
        if (rst_n && bus_req) req_seen++;
    end

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 asking, 2 reading, 3 writing, 4 released, 5 finishing
    int            ph;
    logic [AW-1:0] p_src, p_dst;
    logic [15:0]   p_len;
    bit            p_mode;
    logic [3:0]    p_gap;
    bit            r_done;
    logic [AW-1:0] c_src, c_dst;
    logic [DW-1:0] c_word;
    int            c_left, c_n, c_wait;
    bit            c_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; p_src = '0; p_dst = '0; p_len = '0; p_mode = 0; p_gap = '0;
            r_done = 0; c_src = '0; c_dst = '0; c_word = '0;
            c_left = 0; c_n = 1; c_wait = 0; c_mode = 0;
        end else begin
            int nph;
            bit fin, idle_now;
            idle_now = (ph == 0);
            nph = ph;
            fin = 0;
            if (ph == 1) begin
                if (bus_gnt) nph = 2;
            end else if (ph == 2) begin
                c_word = pattern(c_src);
                nph = 3;
            end else if (ph == 3) begin
                c_src = c_src + 1;
                c_dst = c_dst + 1;
                c_left = c_left - 1;
                if (c_left == 0) nph = 5;
                else if (!c_mode) nph = 2;
                else if (c_n == 1) nph = 1;
                else begin c_wait = c_n - 1; nph = 4; end
            end else if (ph == 4) begin
                if (c_wait == 1) nph = 1;
                else c_wait = c_wait - 1;
            end else if (ph == 5) begin
                nph = 0;
                fin = 1;
            end
            if (reg_we && idle_now) begin
                if (reg_sel == 3'd0) p_src = reg_wdata;
                if (reg_sel == 3'd1) p_dst = reg_wdata;
                if (reg_sel == 3'd2) p_len = reg_wdata[15:0];
                if (reg_sel == 3'd3) begin
                    p_mode = reg_wdata[1];
                    p_gap  = reg_wdata[7:4];
                    if (reg_wdata[0]) begin
                        if (p_len == 0) fin = 1;
                        else begin
                            c_src = p_src; c_dst = p_dst; c_left = int'(p_len);
                            c_mode = p_mode; c_n = (p_gap == 0) ? 1 : int'(p_gap);
                            nph = 1;
                        end
                    end
                end
            end
            if (fin) r_done = 1;
            else if (reg_we && reg_sel == 3'd4 && reg_wdata[1]) r_done = 0;
            ph = nph;
        end
    end

    function automatic logic [AW-1:0] model_read(input logic [2:0] s);
        logic [AW-1:0] v;
        v = '0;
        case (s)
            3'd0: v = p_src;
            3'd1: v = p_dst;
            3'd2: v = AW'(p_len);
            3'd3: begin v[1] = p_mode; v[7:4] = p_gap; end
            3'd4: begin v[0] = (ph != 0); v[1] = r_done; end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, after outputs settle
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk({cur, " bus_req"}, 64'(bus_req), 64'(ph == 1 || ph == 2 || ph == 3));
            chk({cur, " m_rd"},    64'(m_rd),    64'(ph == 2));
            chk({cur, " m_wr"},    64'(m_wr),    64'(ph == 3));
            if (ph == 2) chk({cur, " read addr"},  64'(m_addr), 64'(c_src));
            if (ph == 3) chk({cur, " write addr"}, 64'(m_addr), 64'(c_dst));
            if (ph == 3) chk({cur, " write data"}, 64'(m_wdata), 64'(c_word));
            chk({cur, " reg_rdata"}, 64'(reg_rdata), 64'(model_read(reg_sel)));
        end
    end

    task automatic wr(input logic [2:0] s, input logic [AW-1:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] s, input logic [AW-1:0] v, input string tag);
        @(negedge clk);
        reg_sel = s;
        @(posedge clk);
        #2;
        chk(tag, 64'(reg_rdata), 64'(v));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_sel = 3'd4;
            @(posedge clk);
            #2;
            if (!reg_rdata[0]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual still running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        cur = "R1";
        for (int s = 0; s < 5; s++) rd_chk(3'(s), '0, "R1 reset value");
        chk("R1 bus_req at reset", 64'(bus_req), 64'd0);

        cur = "R2";
        wr(3'd0, 32'h100);
        wr(3'd1, 32'h800);
        wr(3'd2, 32'h0003_0003);
        wr(3'd3, 32'h52);
        rd_chk(3'd0, 32'h100, "R2 src");
        rd_chk(3'd1, 32'h800, "R2 dst");
        rd_chk(3'd2, 32'h3, "R2 len low bits");
        rd_chk(3'd3, 32'h52, "R2 ctrl mode and N");
        rd_chk(3'd4, 32'h0, "R2 no start");

        cur = "R3";
        wr(3'd2, 32'd4);
        cpu_hold = 1'b1;
        base = wr_seen;
        wr(3'd3, 32'h1);
        rd_chk(3'd4, 32'h1, "R3 busy after start");
        repeat (3) @(posedge clk);
        #2 chk("R3 no write before grant", 64'(wr_seen - base), 64'd0);
        cur = "R5";
        cpu_hold = 1'b0;
        wait_idle();
        chk("R4 words written", 64'(wr_seen - base), 64'd4);
        cur = "R7";
        rd_chk(3'd4, 32'h2, "R7 done after run");

        cur = "R10";
        wr(3'd4, 32'h1);
        rd_chk(3'd4, 32'h2, "R10 bit1 zero keeps done");
        wr(3'd4, 32'h2);
        rd_chk(3'd4, 32'h0, "R10 clear done");

        cur = "R6";
        wr(3'd0, 32'h200);
        wr(3'd1, 32'h900);
        wr(3'd2, 32'd3);
        base = wr_seen;
        wr(3'd3, 32'h33);
        wait_idle();
        chk("R6 steal N=3 words", 64'(wr_seen - base), 64'd3);
        wr(3'd2, 32'd2);
        base = wr_seen;
        wr(3'd3, 32'h03);
        wait_idle();
        chk("R6 steal N=0 words", 64'(wr_seen - base), 64'd2);

        cur = "R8";
        wr(3'd4, 32'h2);
        wr(3'd2, 32'd0);
        base = req_seen;
        wr(3'd3, 32'h1);
        rd_chk(3'd4, 32'h2, "R8 zero length done");
        repeat (4) @(posedge clk);
        #2 chk("R8 no request", 64'(req_seen - base), 64'd0);

        cur = "R9";
        wr(3'd0, 32'h300);
        wr(3'd1, 32'hA00);
        wr(3'd2, 32'd5);
        cpu_hold = 1'b1;
        base = wr_seen;
        wr(3'd3, 32'h1);
        wr(3'd0, 32'hDEAD);
        wr(3'd2, 32'd9);
        wr(3'd3, 32'hF3);
        rd_chk(3'd0, 32'h300, "R9 src frozen");
        rd_chk(3'd2, 32'd5, "R9 len frozen");
        rd_chk(3'd3, 32'h0, "R9 ctrl frozen");
        wr(3'd4, 32'h2);
        rd_chk(3'd4, 32'h1, "R9 R10 clear while busy");
        cpu_hold = 1'b0;
        wait_idle();
        chk("R9 transfer unchanged", 64'(wr_seen - base), 64'd5);
        cur = "R7";
        rd_chk(3'd4, 32'h2, "R7 done again");

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule